// File: doc/BRIEF.md
# Clock Source Mode Controller

This block picks which clock drives the CPU and sequences the low-power modes. There are three sources. The internal high-speed oscillator runs from reset. The high-speed system clock comes either from a crystal oscillator or from an external clock input. The low-frequency subsystem clock comes from outside the block, which only watches its ready flag. Software programs four small registers through a simple write port. Three further pulse inputs request HALT, request STOP, and carry a wake-up event.

The oscillators are modelled as enable/ready handshakes. `main_en` switches on the high-speed oscillator. `main_tick` marks each cycle of that oscillator, and an internal counter uses it to time crystal stabilization. `sub_rdy` reports that the subsystem clock is usable. The CPU source output moves to a new source only once that source reports ready. Until then the previous source stays in use, so a clock multiplexer downstream never switches onto a clock that has not settled.

The controller is a single state machine with nine states:
- `ST_RUN_IHS`, `ST_RUN_MAIN` and `ST_RUN_SUB` are the run states, one for each source.
- `ST_HALT_IHS`, `ST_HALT_MAIN` and `ST_HALT_SUB` are the HALT states. Each one remembers its source.
- `ST_STOP_IHS` and `ST_STOP_MAIN` are the STOP states. Both stop the internal oscillator and the high-speed oscillator.
- `ST_WARM_MAIN` restarts the high-speed source after a STOP and waits for it to be ready.

The transitions are:
- run → run, to switch source.
- run → halt, on a HALT request.
- halt → run, on wake-up.
- run → stop, on a STOP request, from the internal or high-speed run state only.
- stop → run, on wake-up, for the internal source.
- stop → warm, on wake-up, for the high-speed source.
- warm → run, once the high-speed source is ready.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset the state is `ST_RUN_IHS`. At reset `cpu_src` = 0 (the internal oscillator), `cpu_run` = 1, `halted` = `stopped` = 0, `ihs_en` = 1 and `main_en` = 0.
- R2: Register addresses and reset readback values:
  - Address 0 is the mode register. Bit 7 selects the external input (1) or the crystal (0). Bit 6 enables the high-speed oscillator. Bit 0 is the frequency-range bit. It reads 0x00 after reset.
  - Address 1 is the oscillator control register. Bit 7 stops the oscillator. It reads 0x80 after reset.
  - Address 2 is the main clock mode register. It holds bits 2 and 0. It reads 0x00 after reset.
  - Address 3 is the processor clock register. Bit 4 selects the subsystem clock. It reads 0x00 after reset.
  - Address 4 is the read-only status register. Bit 0 is the stabilization-complete flag.
  - Bits that are not implemented read 0.
- R3: The frequency-range bit (address 0, bit 0) takes only the first write to address 0 after reset. Later writes leave it unchanged, while bits 7 and 6 stay writable.
- R4: `main_en` is 1 exactly when address 0 bit 6 = 1, address 1 bit 7 = 0, and the block is not in a STOP state.
- R5: The stabilization counter counts `main_tick` pulses while `main_en` = 1 and saturates at `STAB_CYCLES`. Address 4 bit 0 reads 1 once the count has reached `STAB_CYCLES`. The counter clears whenever `main_en` = 0.
- R6: The high-speed source is wanted when address 2 bits 2 and 0 are both 1 and address 3 bit 4 = 0. The block switches to it (`cpu_src` = 1) only when it is ready. With the crystal (bit 7 = 0), ready means `main_en` = 1 and stabilization is complete. With the external input (bit 7 = 1), ready means `main_en` = 1 alone.
- R7: With address 3 bit 4 = 1 the block switches to the subsystem clock (`cpu_src` = 2) only while `sub_rdy` = 1. Until then the current source stays selected.
- R8: A HALT request in any run state enters the matching HALT state: `halted` = 1, `cpu_run` = 0, and `cpu_src` is held. A wake-up returns to the same run state one cycle later.
- R9: A STOP request is ignored while running from the subsystem clock.
- R10: A STOP state drives `stopped` = 1 and `ihs_en` = `main_en` = 0. A wake-up from the internal-source STOP state returns directly to `ST_RUN_IHS`. A wake-up from the high-speed STOP state enters `ST_WARM_MAIN`, where `main_en` = 1. It then enters `ST_RUN_MAIN` only once the source is ready again; a crystal must count out its stabilization time again first.
- R11: In a run state, a STOP request (where it is allowed) has priority over a simultaneous HALT request, and both have priority over a source switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Combinational read data for `addr` |
| halt_req | input | 1 | HALT request pulse |
| stop_req | input | 1 | STOP request pulse |
| wake | input | 1 | Wake-up event |
| main_tick | input | 1 | One pulse per high-speed oscillator cycle |
| sub_rdy | input | 1 | Subsystem clock usable |
| main_en | output | 1 | High-speed oscillator enable |
| ihs_en | output | 1 | Internal high-speed oscillator enable |
| cpu_src | output | 2 | CPU source: 0 internal, 1 high-speed, 2 subsystem |
| cpu_run | output | 1 | CPU clock running (run state) |
| halted | output | 1 | In a HALT state |
| stopped | output | 1 | In a STOP state |

## Verification
The bench builds the block with `STAB_CYCLES` = 3. With that value, a sweep of tick counts across the whole stabilization window, one below it and one past it, takes only a few cycles. That brings within reach the exact cycle where the done flag rises and the cycle after it where the source switches. The same small window lets the bench repeat the crystal warm-up after a STOP and compare it with the external-input path, which needs no count at all. Every state of the machine and every named transition is visited, including the refused STOP on the subsystem clock and the STOP-over-HALT priority.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_OSC   = 3'd1;
    localparam logic [ADDR_W-1:0] A_MCM   = 3'd2;
    localparam logic [ADDR_W-1:0] A_PCC   = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

    typedef enum logic [1:0] {
        SRC_IHS  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_SUB  = 2'd2
    } cs_src_e;

    typedef enum logic [3:0] {
        ST_RUN_IHS,
        ST_RUN_MAIN,
        ST_RUN_SUB,
        ST_HALT_IHS,
        ST_HALT_MAIN,
        ST_HALT_SUB,
        ST_STOP_IHS,
        ST_STOP_MAIN,
        ST_WARM_MAIN
    } cs_state_e;

endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              stab_done,
    output logic [REG_W-1:0]  rdata,
    output logic              ext_sel,
    output logic              osc_on,
    output logic              range_hi,
    output logic              range_lock,
    output logic              osc_stop,
    output logic              want_main,
    output logic              want_sub
);

    logic mcm_hi, mcm_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_sel    <= 1'b0;
            osc_on     <= 1'b0;
            range_hi   <= 1'b0;
            range_lock <= 1'b0;
            osc_stop   <= 1'b1;
            mcm_hi     <= 1'b0;
            mcm_lo     <= 1'b0;
            want_sub   <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_MODE: begin
                    ext_sel    <= wdata[7];
                    osc_on     <= wdata[6];
                    range_lock <= 1'b1;
                    if (!range_lock) range_hi <= wdata[0];
                end
                A_OSC:   osc_stop <= wdata[7];
                A_MCM: begin
                    mcm_hi <= wdata[2];
                    mcm_lo <= wdata[0];
                end
                A_PCC:   want_sub <= wdata[4];
                default: ;
            endcase
        end
    end

    assign want_main = mcm_hi & mcm_lo;

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:  rdata = {ext_sel, osc_on, 5'b0, range_hi};
            A_OSC:   rdata = {osc_stop, 7'b0};
            A_MCM:   rdata = {5'b0, mcm_hi, 1'b0, mcm_lo};
            A_PCC:   rdata = {3'b0, want_sub, 4'b0};
            A_STAT:  rdata = {7'b0, stab_done};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/clksel_stab.sv
module clksel_stab #(
    parameter int STAB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);

    localparam int CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STAB_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!run)              cnt <= '0;
        else if (tick && !done)     cnt <= cnt + CW'(1);
    end

    assign done = (cnt == LIMIT);

endmodule

// File: rtl/clksel_fsm.sv
module clksel_fsm
    import clksel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       stop_req,
    input  logic       wake,
    input  logic       want_main,
    input  logic       want_sub,
    input  logic       main_rdy,
    input  logic       sub_rdy,
    output logic [1:0] cpu_src,
    output logic       cpu_run,
    output logic       halted,
    output logic       stopped
);

    cs_state_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN_IHS;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_RUN_IHS: begin
                if (stop_req)                           nxt = ST_STOP_IHS;
                else if (halt_req)                      nxt = ST_HALT_IHS;
                else if (want_sub && sub_rdy)           nxt = ST_RUN_SUB;
                else if (!want_sub && want_main && main_rdy) nxt = ST_RUN_MAIN;
            end
            ST_RUN_MAIN: begin
                if (stop_req)                           nxt = ST_STOP_MAIN;
                else if (halt_req)                      nxt = ST_HALT_MAIN;
                else if (want_sub && sub_rdy)           nxt = ST_RUN_SUB;
                else if (!want_sub && !want_main)       nxt = ST_RUN_IHS;
            end
            ST_RUN_SUB: begin
                if (halt_req)                           nxt = ST_HALT_SUB;
                else if (!want_sub && want_main && main_rdy) nxt = ST_RUN_MAIN;
                else if (!want_sub && !want_main)       nxt = ST_RUN_IHS;
            end
            ST_HALT_IHS:  if (wake) nxt = ST_RUN_IHS;
            ST_HALT_MAIN: if (wake) nxt = ST_RUN_MAIN;
            ST_HALT_SUB:  if (wake) nxt = ST_RUN_SUB;
            ST_STOP_IHS:  if (wake) nxt = ST_RUN_IHS;
            ST_STOP_MAIN: if (wake) nxt = ST_WARM_MAIN;
            ST_WARM_MAIN: if (main_rdy) nxt = ST_RUN_MAIN;
            default:      nxt = ST_RUN_IHS;
        endcase
    end

    always_comb begin
        cpu_src = SRC_IHS;
        cpu_run = 1'b0;
        halted  = 1'b0;
        stopped = 1'b0;
        unique case (st)
            ST_RUN_IHS:   cpu_run = 1'b1;
            ST_RUN_MAIN:  begin cpu_run = 1'b1; cpu_src = SRC_MAIN; end
            ST_RUN_SUB:   begin cpu_run = 1'b1; cpu_src = SRC_SUB;  end
            ST_HALT_IHS:  halted = 1'b1;
            ST_HALT_MAIN: begin halted = 1'b1;  cpu_src = SRC_MAIN; end
            ST_HALT_SUB:  begin halted = 1'b1;  cpu_src = SRC_SUB;  end
            ST_STOP_IHS:  stopped = 1'b1;
            ST_STOP_MAIN: begin stopped = 1'b1; cpu_src = SRC_MAIN; end
            ST_WARM_MAIN: cpu_src = SRC_MAIN;
            default:      cpu_src = SRC_IHS;
        endcase
    end

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int STAB_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              halt_req,
    input  logic              stop_req,
    input  logic              wake,
    input  logic              main_tick,
    input  logic              sub_rdy,
    output logic              main_en,
    output logic              ihs_en,
    output logic [1:0]        cpu_src,
    output logic              cpu_run,
    output logic              halted,
    output logic              stopped
);

    logic ext_sel, osc_on, range_hi, range_lock, osc_stop;
    logic want_main, want_sub, stab_done, main_rdy;

    clksel_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .stab_done  (stab_done),
        .rdata      (rdata),
        .ext_sel    (ext_sel),
        .osc_on     (osc_on),
        .range_hi   (range_hi),
        .range_lock (range_lock),
        .osc_stop   (osc_stop),
        .want_main  (want_main),
        .want_sub   (want_sub)
    );

    clksel_stab #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (main_en),
        .tick  (main_tick),
        .done  (stab_done)
    );

    clksel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_req  (halt_req),
        .stop_req  (stop_req),
        .wake      (wake),
        .want_main (want_main),
        .want_sub  (want_sub),
        .main_rdy  (main_rdy),
        .sub_rdy   (sub_rdy),
        .cpu_src   (cpu_src),
        .cpu_run   (cpu_run),
        .halted    (halted),
        .stopped   (stopped)
    );

    assign main_en  = osc_on & ~osc_stop & ~stopped;
    assign ihs_en   = ~stopped;
    assign main_rdy = main_en & (ext_sel | stab_done);

endmodule

// File: rtl/clksel_chk.sv
module clksel_chk
    import clksel_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       wake,
    input logic       sub_rdy,
    input logic       main_rdy,
    input logic       main_en,
    input logic       stab_done,
    input logic       range_hi,
    input logic       range_lock,
    input logic [1:0] cpu_src,
    input logic       cpu_run,
    input logic       halted,
    input logic       stopped
);

    assert_range_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        range_lock |=> $stable(range_hi));

    assert_stab_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !main_en |=> !stab_done);

    assert_main_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_src != SRC_MAIN && !main_rdy) |=> cpu_src != SRC_MAIN);

    assert_sub_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_src != SRC_SUB && !sub_rdy) |=> cpu_src != SRC_SUB);

    assert_halt_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && wake) |=> (cpu_run && $stable(cpu_src)));

    assert_no_stop_on_sub_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && cpu_src == SRC_SUB) |=> !stopped);

    assert_stop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !wake) |=> stopped);

    assert_one_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_run, halted, stopped}));

    assert_stop_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && cpu_src != SRC_SUB && stop_req) |=> stopped);

endmodule

bind clksel_ctrl clksel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .wake       (wake),
    .sub_rdy    (sub_rdy),
    .main_rdy   (main_rdy),
    .main_en    (main_en),
    .stab_done  (stab_done),
    .range_hi   (range_hi),
    .range_lock (range_lock),
    .cpu_src    (cpu_src),
    .cpu_run    (cpu_run),
    .halted     (halted),
    .stopped    (stopped)
);

// File: tb/clksel_ctrl_tb_top.sv
module clksel_ctrl_tb_top;

    localparam int LIM = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       halt_req = 1'b0, stop_req = 1'b0, wake = 1'b0;
    logic       main_tick = 1'b0, sub_rdy = 1'b0;
    logic       main_en, ihs_en, cpu_run, halted, stopped;
    logic [1:0] cpu_src;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    clksel_ctrl #(.STAB_CYCLES(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .halt_req(halt_req), .stop_req(stop_req), .wake(wake),
        .main_tick(main_tick), .sub_rdy(sub_rdy), .main_en(main_en),
        .ihs_en(ihs_en), .cpu_src(cpu_src), .cpu_run(cpu_run),
        .halted(halted), .stopped(stopped)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input int exp);
        addr = a;
        #0.1;
        check(req, int'(rdata), exp);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cpu_src", cpu_src, 0);
        check("R1 cpu_run", cpu_run, 1);
        check("R1 halted/stopped", {halted, stopped}, 0);
        check("R1 ihs_en", ihs_en, 1);
        check("R1 main_en", main_en, 0);
        // R2 reset readback
        rd_check("R2 mode", 3'd0, 8'h00);
        rd_check("R2 osc", 3'd1, 8'h80);
        rd_check("R2 mcm", 3'd2, 8'h00);
        rd_check("R2 pcc", 3'd3, 8'h00);
        rd_check("R2 stat", 3'd4, 8'h00);

        // R4 oscillator stays off while mode bit 6 is clear
        wr(3'd1, 8'h00);
        check("R4 main_en bit6=0", main_en, 0);
        // R2/R3 first mode write takes range bit
        wr(3'd0, 8'hFF);
        rd_check("R2 mode mask", 3'd0, 8'hC1);
        check("R4 main_en on", main_en, 1);
        wr(3'd0, 8'h40);
        rd_check("R3 range locked", 3'd0, 8'h41);
        wr(3'd3, 8'hFF);
        rd_check("R2 pcc mask", 3'd3, 8'h10);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'hFF);
        rd_check("R2 mcm mask", 3'd2, 8'h05);
        step();
        check("R6 no switch before stable", cpu_src, 0);

        // R5/R6 stabilization sweep, crystal
        for (int k = 1; k <= LIM + 1; k++) begin
            main_tick = 1'b1;
            step();
            main_tick = 1'b0;
            rd_check("R5 stab done", 3'd4, (k >= LIM) ? 1 : 0);
            check("R6 switch after done", cpu_src, (k >= LIM + 1) ? 1 : 0);
        end

        // R8 halt on high-speed clock
        halt_req = 1'b1; step(); halt_req = 1'b0;
        check("R8 halted main", {halted, cpu_run}, 2'b10);
        check("R8 src held", cpu_src, 1);
        wake = 1'b1; step(); wake = 1'b0;
        check("R8 resume main", {cpu_run, cpu_src}, 3'b101);

        // R10 stop on high-speed clock, crystal warm-up
        stop_req = 1'b1; step(); stop_req = 1'b0;
        check("R10 stopped", stopped, 1);
        check("R10 osc off", {main_en, ihs_en}, 0);
        step();
        rd_check("R5 cleared in stop", 3'd4, 0);
        wake = 1'b1; step(); wake = 1'b0;
        check("R10 warm no run", {cpu_run, stopped, main_en}, 3'b001);
        for (int k = 1; k <= LIM; k++) begin
            main_tick = 1'b1; step(); main_tick = 1'b0;
            check("R10 warm waits", cpu_run, 0);
        end
        step();
        check("R10 warm done", {cpu_run, cpu_src}, 3'b101);

        // R7 switch to subsystem gated by ready
        wr(3'd3, 8'h10);
        step();
        check("R7 wait sub_rdy", cpu_src, 1);
        sub_rdy = 1'b1;
        step();
        check("R7 on sub", cpu_src, 2);

        // R9 stop refused on subsystem
        stop_req = 1'b1; step(); stop_req = 1'b0;
        check("R9 stop ignored", {cpu_run, stopped, cpu_src}, 4'b1010);
        // R8 halt on subsystem
        halt_req = 1'b1; step(); halt_req = 1'b0;
        check("R8 halted sub", {halted, cpu_src}, 3'b110);
        wake = 1'b1; step(); wake = 1'b0;
        check("R8 resume sub", {cpu_run, cpu_src}, 3'b110);

        // back to internal oscillator
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        step();
        check("R6 back to internal", cpu_src, 0);

        // R11 stop beats halt
        stop_req = 1'b1; halt_req = 1'b1; step();
        stop_req = 1'b0; halt_req = 1'b0;
        check("R11 stop wins", {stopped, halted}, 2'b10);
        wake = 1'b1; step(); wake = 1'b0;
        check("R10 wake internal", {cpu_run, cpu_src}, 3'b100);

        // R3/R6 external input: no stabilization wait
        wr(3'd0, 8'hC0);
        rd_check("R3 range kept", 3'd0, 8'hC1);
        wr(3'd2, 8'h05);
        step();
        check("R6 external switch", cpu_src, 1);
        rd_check("R6 no count needed", 3'd4, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule